// File: doc/BRIEF.md
# Three-Channel Match and Overflow Timer

A register-mapped peripheral holding three independent counters. Each counter has a count value, a reload value and two compare values. One shared control word sets four things for every counter: whether it runs, whether it steps on every bus clock or only on rising edges of an external tick, whether its wrap event raises a flag, and whether it counts up or down. When a counter wraps past its end value, it takes its reload value. When the value a counter steps to equals one of its compare values, the matching flag sets.

The nine event flags, three per counter, sit in one status word. Software clears a flag by writing 1 to its bit. A mask word selects which flags may drive the single interrupt output. Software reaches every register through a simple one-cycle register bus. Reads are combinational on the selected byte offset, and writes take effect at the next clock edge.

Top module: `tri_timer`

## Requirements
- R1: After reset, all count, reload, compare, control and status registers read 0, the mask reads 0x1FF and `irq` is low.
- R2: Counter n (n=1..3) has its count at offset 0x10*(n-1)+0x0, its reload at +0x4, compare A at +0x8 and compare B at +0xC. The control word is at 0x30, status at 0x34 and mask at 0x38. A write takes effect at the next clock edge and reads back unchanged. Any other offset, and any offset not a multiple of 4, reads 0 and ignores writes.
- R3: Control bit 3*(n-1) runs counter n, and bit 9+(n-1) set makes it count up. With clock-select bit 3*(n-1)+1 at 0, a running counter steps once per clock. A stopped counter holds its value. A bus write to a count register loads that value, and the write wins over a step in the same cycle.
- R4: With its direction bit at 0, a running counter decrements by one on each step.
- R5: An up-counting counter stepping from 0xFFFFFFFF loads its reload value instead. If its control bit 3*(n-1)+2 is 1, it also sets status bit 3*(n-1)+2. A reload of 0xFFFFFFFF-(P-1) therefore gives one wrap flag every P steps.
- R6: A down-counting counter stepping from 0 loads its reload value. It sets the same wrap flag under the same enable bit.
- R7: When a step moves counter n to a value equal to compare A, status bit 3*(n-1) sets. When the value equals compare B, status bit 3*(n-1)+1 sets.
- R8: Status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R9: `irq` is high exactly when some status bit is 1 and its mask bit is 0.
- R10: With its clock-select bit at 1, a running counter steps once for each rising edge of `ext_tick`. The edge is seen after two synchronizing flops, and the step lands three clock edges after the input rises. A level held high gives only one step.
- R11: With the wrap-flag enable bit at 0, a wrap still reloads the counter but sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| ext_tick | input | 1 | Asynchronous external count source |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The bench builds the block with its defaults: 32-bit counters and an 8-bit address. The 8-bit address puts offsets past 0x3F, such as 0x40, within reach of the unused-offset check. Wrap behaviour at full width comes within reach by preloading counts a few steps short of 0xFFFFFFFF or of zero, rather than by running through the whole range. A reload of 0xFFFFFFFD shows the three-step period. Compare, clear-collision and external-tick cases are timed edge by edge so that each flag change lands on a known cycle.

// File: rtl/tri_timer.sv
module tri_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ext_tick,
  output logic              irq
);
  localparam int NT  = 3;
  localparam int AW2 = ADDR_W - 2;
  localparam int NF  = 3 * NT;
  localparam int CW  = 4 * NT;

  logic [CW-1:0]    ctrl;
  logic [NF-1:0]    status, mask, ev, st_clr;
  logic [2:0]       xs;
  logic             ext_rise, aligned, acc, wr_en, wr_st;
  logic [AW2-1:0]   widx;
  logic [CNT_W-1:0] cnt_q [NT];
  logic [CNT_W-1:0] load_q [NT];
  logic [CNT_W-1:0] ma_q [NT];
  logic [CNT_W-1:0] mb_q [NT];
  logic [2:0]       ev_t [NT];
  logic             wr_cnt [NT];

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign widx     = bus_addr[ADDR_W-1:2];
  assign acc      = bus_sel & aligned;
  assign wr_en    = acc & bus_wr;
  assign wr_st    = wr_en && (widx == AW2'(13));
  assign st_clr   = wr_st ? bus_wdata[NF-1:0] : '0;
  assign ext_rise = xs[1] & ~xs[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) xs <= '0;
    else        xs <= {xs[1:0], ext_tick};

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic [CNT_W-1:0] c, ld, ma, mb, nxt;
    logic en, up, ie, sx, tk, wrap;

    assign en   = ctrl[3*i];
    assign sx   = ctrl[3*i+1];
    assign ie   = ctrl[3*i+2];
    assign up   = ctrl[9+i];
    assign tk   = en & (sx ? ext_rise : 1'b1);
    assign wrap = up ? (&c) : ~(|c);
    assign nxt  = wrap ? ld : (up ? c + 1'b1 : c - 1'b1);

    assign wr_cnt[i] = wr_en && (widx == AW2'(4*i));
    assign ev_t[i]   = {tk & wrap & ie, tk & (nxt == mb), tk & (nxt == ma)};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        c <= '0; ld <= '0; ma <= '0; mb <= '0;
      end else begin
        if (wr_cnt[i])                           c  <= bus_wdata[CNT_W-1:0];
        else if (tk)                             c  <= nxt;
        if (wr_en && (widx == AW2'(4*i+1)))      ld <= bus_wdata[CNT_W-1:0];
        if (wr_en && (widx == AW2'(4*i+2)))      ma <= bus_wdata[CNT_W-1:0];
        if (wr_en && (widx == AW2'(4*i+3)))      mb <= bus_wdata[CNT_W-1:0];
      end

    assign cnt_q[i]  = c;
    assign load_q[i] = ld;
    assign ma_q[i]   = ma;
    assign mb_q[i]   = mb;
  end

  always_comb
    for (int i = 0; i < NT; i++) ev[3*i +: 3] = ev_t[i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl   <= '0;
      mask   <= '1;
      status <= '0;
    end else begin
      if (wr_en && (widx == AW2'(12))) ctrl <= bus_wdata[CW-1:0];
      if (wr_en && (widx == AW2'(14))) mask <= bus_wdata[NF-1:0];
      status <= (status & ~st_clr) | ev;
    end

  always_comb begin
    bus_rdata = '0;
    if (acc) begin
      for (int i = 0; i < NT; i++) begin
        if (widx == AW2'(4*i))   bus_rdata = 32'(cnt_q[i]);
        if (widx == AW2'(4*i+1)) bus_rdata = 32'(load_q[i]);
        if (widx == AW2'(4*i+2)) bus_rdata = 32'(ma_q[i]);
        if (widx == AW2'(4*i+3)) bus_rdata = 32'(mb_q[i]);
      end
      if (widx == AW2'(12)) bus_rdata = 32'(ctrl);
      if (widx == AW2'(13)) bus_rdata = 32'(status);
      if (widx == AW2'(14)) bus_rdata = 32'(mask);
    end
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      ctrl,
  input logic [8:0]       status,
  input logic [8:0]       st_clr,
  input logic             irq,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] load0,
  input logic             wr_cnt0
);
  logic [8:0] keep;
  assign keep = status & ~st_clr;

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !wr_cnt0) |=> $stable(cnt0));

  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[1] && !ctrl[9] && (|cnt0) && !wr_cnt0) |=> (cnt0 == $past(cnt0) - 1'b1));

  p_up_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[1] && ctrl[9] && (&cnt0) && !wr_cnt0) |=> (cnt0 == $past(load0)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(keep)) == $past(keep)));

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|status));
endmodule

bind tri_timer tri_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .status(status), .st_clr(st_clr),
  .irq(irq), .cnt0(cnt_q[0]), .load0(load_q[0]), .wr_cnt0(wr_cnt[0])
);

// File: tb/tri_timer_bench.sv
`timescale 1ns/1ps
module tri_timer_bench;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0, ext_tick = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tri_timer u_tri_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .irq(irq)
  );

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic brd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); bus_sel = 0; bus_wr = 0; end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    #1;
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (bus_sel && !bus_wr && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s addr %h actual %h expected %h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    brd(8'h00, 0, "R1 count1"); brd(8'h24, 0, "R1 load3"); brd(8'h30, 0, "R1 ctrl");
    brd(8'h34, 0, "R1 status"); brd(8'h38, 32'h1FF, "R1 mask");
    chk_irq(0, "R1");
    // R2 register map
    bwr(8'h14, 32'hA5A5_0001); bwr(8'h2C, 32'h0000_1234);
    bwr(8'h08, 32'h7777_0000); bwr(8'h0C, 32'h7777_0001);
    bwr(8'h3C, 32'hFFFF_FFFF); bwr(8'h01, 32'hDEAD_BEEF);
    brd(8'h14, 32'hA5A5_0001, "R2 load2"); brd(8'h2C, 32'h1234, "R2 cmpB3");
    brd(8'h08, 32'h7777_0000, "R2 cmpA1");
    brd(8'h3C, 0, "R2 unused 3C"); brd(8'h40, 0, "R2 unused 40");
    brd(8'h01, 0, "R2 misaligned"); brd(8'h00, 0, "R2 misaligned write ignored");
    // R3 up count, 5 steps, then hold
    bwr(8'h30, 32'h201); idle(4); bwr(8'h30, 32'h200);
    brd(8'h00, 5, "R3 up count"); idle(3); brd(8'h00, 5, "R3 stopped hold");
    // R4 down count
    bwr(8'h00, 10); bwr(8'h30, 32'h001); idle(2); bwr(8'h30, 0);
    brd(8'h00, 7, "R4 down count");
    // R5 up wrap with period 3
    bwr(8'h00, 32'hFFFF_FFFE); bwr(8'h04, 32'hFFFF_FFFD);
    bwr(8'h30, 32'h205); idle(1); bwr(8'h30, 32'h200);
    brd(8'h00, 32'hFFFF_FFFD, "R5 reload"); brd(8'h34, 32'h4, "R5 wrap flag");
    chk_irq(0, "R9 masked");
    bwr(8'h38, 32'h1FB); chk_irq(1, "R9 unmasked");
    bwr(8'h34, 32'h4); brd(8'h34, 0, "R8 clear"); chk_irq(0, "R9 after clear");
    bwr(8'h30, 32'h205); idle(1); bwr(8'h30, 32'h200);
    brd(8'h34, 0, "R5 two steps no wrap");
    bwr(8'h30, 32'h205); bwr(8'h30, 32'h200);
    brd(8'h34, 32'h4, "R5 third step wraps"); brd(8'h00, 32'hFFFF_FFFD, "R5 period");
    bwr(8'h34, 32'h4);
    // R11 wrap flag disabled
    bwr(8'h00, 32'hFFFF_FFFF); bwr(8'h04, 32'h100);
    bwr(8'h30, 32'h201); bwr(8'h30, 32'h200);
    brd(8'h00, 32'h100, "R11 reload"); brd(8'h34, 0, "R11 no flag");
    // R6 down wrap
    bwr(8'h00, 1); bwr(8'h04, 32'h50);
    bwr(8'h30, 32'h005); idle(1); bwr(8'h30, 0);
    brd(8'h00, 32'h50, "R6 reload"); brd(8'h34, 32'h4, "R6 wrap flag");
    bwr(8'h34, 32'h4);
    // R7 compares
    bwr(8'h00, 0); bwr(8'h08, 3); bwr(8'h0C, 5);
    bwr(8'h30, 32'h201); idle(2); bwr(8'h30, 32'h200);
    brd(8'h34, 32'h1, "R7 cmpA only");
    bwr(8'h30, 32'h201); idle(1); bwr(8'h30, 32'h200);
    brd(8'h34, 32'h3, "R7 cmpA and cmpB"); brd(8'h00, 5, "R7 count");
    bwr(8'h34, 32'h3); brd(8'h34, 0, "R8 clear both");
    // R8 event beats clear
    bwr(8'h00, 2);
    bwr(8'h30, 32'h201); bwr(8'h34, 32'h1); bwr(8'h30, 32'h200);
    brd(8'h34, 32'h1, "R8 event wins");
    bwr(8'h34, 0); brd(8'h34, 32'h1, "R8 write 0 no effect");
    bwr(8'h34, 32'h1); brd(8'h34, 0, "R8 final clear");
    // R10 external tick
    bwr(8'h00, 0); bwr(8'h30, 32'h203); idle(1);
    for (int k = 0; k < 3; k++) begin
      ext_tick = 1; idle(3); ext_tick = 0; idle(3);
    end
    idle(4); bwr(8'h30, 32'h200);
    brd(8'h00, 3, "R10 three edges");
    bwr(8'h30, 32'h203); ext_tick = 1; idle(10); bwr(8'h30, 32'h200); ext_tick = 0;
    brd(8'h00, 4, "R10 held level one step");
    // R3 third counter independent
    bwr(8'h20, 0); bwr(8'h30, 32'h840); idle(2);
    brd(8'h30, 32'h840, "R2 ctrl readback"); bwr(8'h30, 0);
    brd(8'h20, 4, "R3 counter3"); brd(8'h10, 0, "R3 counter2 untouched");
    brd(8'h00, 4, "R3 counter1 untouched");
    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule